// File: doc/BRIEF.md
# Transmit Frame Queue Drain Controller

This block sits between a byte-wide frame writer and a MAC transmitter. Frames are pushed into an internal byte queue together with start and end marks. A read-side state machine hands only complete frames to the transmitter over a valid/ready byte stream, and it flags the final byte of each frame. Once a frame's last byte has left, the controller waits for the transmitter to return a status word for that frame. It then presents that word on a one-cycle write-back strobe, and only after that may the next frame start. A flush input discards everything stored in the queue. Flushing shares the same externally visible code as status write-back.

The read-side machine has five states: IDLE, SEND, WAIT, WBACK and FLUSH.
- IDLE moves to SEND when a complete frame is stored, and to FLUSH when flush is high.
- SEND moves to WAIT when the last byte is accepted, and to FLUSH on flush.
- WAIT moves to WBACK when a status word is taken, and to FLUSH on flush.
- WBACK always moves to IDLE.
- FLUSH always moves to IDLE.

The 2-bit status code maps IDLE to 00, SEND to 01 and WAIT to 10. Both WBACK and FLUSH report 11. Three further flags show the queue and the writer: full, not-empty and write-active. When the code and all three flags are zero, the controller is idle with an empty queue.

Top module: `txq_drain`

## Requirements
- R1: After reset, and after every drained frame once the queue is empty, the status code is 00 and the full, not-empty and write-active flags are all 0.
- R2: The status code is 00 in IDLE, 01 in SEND, 10 in WAIT, and 11 in both WBACK and FLUSH.
- R3: The controller stays in IDLE, with tx_valid low, while the queue holds only an incomplete frame (no stored end mark).
- R4: Bytes reach the transmitter in the order they were written. tx_last is high exactly on the byte that was written with the end mark, and tx_valid is high only in SEND.
- R5: In the cycle after the last byte is accepted, the code is 10, tx_valid is low and st_ready is high. This persists until a status word is taken, even when further frames are stored.
- R6: The cycle after a status word is taken (st_valid and st_ready both high), ret_valid is high for exactly one cycle, ret_word equals the taken word, and the code is 11. The next cycle is IDLE.
- R7: The queue holds 64 bytes. When 64 bytes are stored, fifo_full is high and wr_ready is low, so no byte is accepted and a writer with a long frame stalls.
- R8: fifo_nempty is high whenever at least one byte is stored.
- R9: wr_active goes high after a start-marked byte without an end mark is accepted. It goes low after the end-marked byte is accepted.
- R10: A flush pulse in IDLE, SEND or WAIT puts the code at 11 for one cycle. The code then returns to 00 with fifo_nempty low, and no discarded byte is ever presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Writer offers a byte |
| wr_ready | output | 1 | Queue accepts a byte this cycle |
| wr_data | input | 8 | Byte to store |
| wr_sof | input | 1 | Byte opens a frame |
| wr_eof | input | 1 | Byte closes a frame |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter takes the byte |
| tx_data | output | 8 | Byte to the transmitter |
| tx_last | output | 1 | Byte is the frame's final byte |
| st_valid | input | 1 | Transmitter returns a status word |
| st_ready | output | 1 | Controller takes the status word |
| st_word | input | 16 | Returned status word |
| ret_valid | output | 1 | One-cycle write-back strobe |
| ret_word | output | 16 | Status word being written back |
| flush | input | 1 | Discard queue contents |
| rd_status | output | 2 | Read-side status code |
| fifo_full | output | 1 | Queue holds 64 bytes |
| fifo_nempty | output | 1 | Queue holds at least one byte |
| wr_active | output | 1 | Writer is inside a frame |

## Verification
The bench parks a partial frame in the queue to catch a design that starts sending before the end mark arrives; such a design would present bytes early with the code at 01. It fills the queue with a 64-byte frame while the transmitter is held off. A design with a wrong full threshold would either take a 65th byte, which then shows up as an extra byte or a non-empty queue after draining, or stall early. After every last byte, the bench holds the status return back for a random time with more frames already queued, so a design that skips the wait would emit the next frame's data with the code at 01 instead of 10. A flush issued while a frame is ready to send must leave the code at 11 for one cycle and then at 00 with an empty queue. A design that kept stale bytes would raise tx_valid afterwards.

// File: rtl/txq_pkg.sv
package txq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEND,
        S_WAIT,
        S_WBACK,
        S_FLUSH
    } rd_state_e;

    function automatic logic [1:0] code_of(rd_state_e s);
        logic [1:0] c;
        unique case (s)
            S_IDLE:  c = 2'b00;
            S_SEND:  c = 2'b01;
            S_WAIT:  c = 2'b10;
            S_WBACK: c = 2'b11;
            S_FLUSH: c = 2'b11;
            default: c = 2'b00;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/txq_store.sv
module txq_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_byte,
    input  logic          wr_eof,
    input  logic          rd_en,
    output logic [DW-1:0] rd_byte,
    output logic          rd_eof,
    output logic          full,
    output logic          nempty,
    output logic          has_frame
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

    logic [DW:0] mem [DEPTH];
    logic [AW:0] wptr, rptr, count, frames;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr[AW-1:0]] <= {wr_eof, wr_byte};
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wptr   <= '0;
            rptr   <= '0;
            count  <= '0;
            frames <= '0;
        end else begin
            if (wr_en) wptr <= wptr + 1'b1;
            if (rd_en) rptr <= rptr + 1'b1;
            count  <= count + (AW+1)'(wr_en) - (AW+1)'(rd_en);
            frames <= frames + (AW+1)'(wr_en && wr_eof) - (AW+1)'(rd_en && rd_eof);
        end
    end

    always_comb begin
        rd_byte   = mem[rptr[AW-1:0]][DW-1:0];
        rd_eof    = mem[rptr[AW-1:0]][DW];
        full      = (count == LIMIT);
        nempty    = (count != '0);
        has_frame = (frames != '0);
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LIMIT);
    assert_frames_fit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frames <= count);

endmodule

// File: rtl/txq_wrtrack.sv
module txq_wrtrack (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic fire,
    input  logic sof,
    input  logic eof,
    output logic active
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            active <= 1'b0;
        end else if (fire) begin
            if (eof)      active <= 1'b0;
            else if (sof) active <= 1'b1;
        end
    end

    assert_active_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && eof) |=> !active);

endmodule

// File: rtl/txq_rdfsm.sv
module txq_rdfsm
    import txq_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          has_frame,
    input  logic          flush,
    input  logic          tx_ready,
    input  logic          rd_eof,
    input  logic          st_valid,
    input  logic [SW-1:0] st_word,
    output logic          tx_valid,
    output logic          tx_last,
    output logic          rd_en,
    output logic          st_ready,
    output logic          ret_valid,
    output logic [SW-1:0] ret_word,
    output logic [1:0]    code,
    output logic          clear,
    output logic          flushing
);
    rd_state_e state, nxt;
    logic [SW-1:0] held;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            held  <= '0;
        end else begin
            state <= nxt;
            if (st_valid && st_ready) held <= st_word;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (flush) nxt = S_FLUSH;
                     else if (has_frame) nxt = S_SEND;
            S_SEND:  if (flush) nxt = S_FLUSH;
                     else if (tx_ready && rd_eof) nxt = S_WAIT;
            S_WAIT:  if (flush) nxt = S_FLUSH;
                     else if (st_valid) nxt = S_WBACK;
            S_WBACK: nxt = S_IDLE;
            S_FLUSH: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        tx_valid  = (state == S_SEND);
        tx_last   = tx_valid && rd_eof;
        rd_en     = tx_valid && tx_ready;
        st_ready  = (state == S_WAIT) && !flush;
        ret_valid = (state == S_WBACK);
        ret_word  = held;
        code      = code_of(state);
        clear     = (state == S_FLUSH);
        flushing  = (state == S_FLUSH);
    end

    assert_wait_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last && !flush) |=> (code == 2'b10 && !tx_valid));
    assert_wback_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> (!ret_valid && code == 2'b00));
    assert_wback_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready) |=> (ret_valid && ret_word == $past(st_word)));

endmodule

// File: rtl/txq_drain.sv
module txq_drain #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int SW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_sof,
    input  logic          wr_eof,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [DW-1:0] tx_data,
    output logic          tx_last,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [SW-1:0] st_word,
    output logic          ret_valid,
    output logic [SW-1:0] ret_word,
    input  logic          flush,
    output logic [1:0]    rd_status,
    output logic          fifo_full,
    output logic          fifo_nempty,
    output logic          wr_active
);
    logic clear, flushing, rd_en, rd_eof, has_frame, wr_fire;

    assign wr_ready = !fifo_full && !flushing;
    assign wr_fire  = wr_valid && wr_ready;

    txq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .wr_en(wr_fire), .wr_byte(wr_data), .wr_eof(wr_eof),
        .rd_en(rd_en), .rd_byte(tx_data), .rd_eof(rd_eof),
        .full(fifo_full), .nempty(fifo_nempty), .has_frame(has_frame)
    );

    txq_wrtrack u_track (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .fire(wr_fire), .sof(wr_sof), .eof(wr_eof), .active(wr_active)
    );

    txq_rdfsm #(.SW(SW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .has_frame(has_frame), .flush(flush),
        .tx_ready(tx_ready), .rd_eof(rd_eof), .st_valid(st_valid),
        .st_word(st_word), .tx_valid(tx_valid), .tx_last(tx_last),
        .rd_en(rd_en), .st_ready(st_ready), .ret_valid(ret_valid),
        .ret_word(ret_word), .code(rd_status), .clear(clear),
        .flushing(flushing)
    );

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status == 2'b11 && !ret_valid) |=> (rd_status == 2'b00 && !fifo_nempty));
    assert_idle_needs_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status == 2'b00 && !has_frame) |=> !tx_valid);
    assert_full_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !wr_ready);

endmodule

// File: tb/sim_txq_drain.sv
module sim_txq_drain;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic wr_valid = 0, wr_sof = 0, wr_eof = 0, tx_ready = 0, st_valid = 0, flush = 0;
    logic [7:0] wr_data = 0;
    logic [15:0] st_word = 0;
    logic wr_ready, tx_valid, tx_last, st_ready, ret_valid, fifo_full, fifo_nempty, wr_active;
    logic [7:0] tx_data;
    logic [15:0] ret_word;
    logic [1:0] rd_status;

    int checks = 0, errors = 0, rframe = 0;
    bit done = 0;
    logic [8:0] expq[$];

    txq_drain u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .wr_sof(wr_sof), .wr_eof(wr_eof),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .st_valid(st_valid), .st_ready(st_ready), .st_word(st_word),
        .ret_valid(ret_valid), .ret_word(ret_word), .flush(flush),
        .rd_status(rd_status), .fifo_full(fifo_full), .fifo_nempty(fifo_nempty),
        .wr_active(wr_active)
    );

    function automatic logic [15:0] status_for(int n);
        return 16'((n * 4951 + 195) & 16'hffff);
    endfunction

    function automatic logic [8:0] pack_exp(logic [7:0] d, logic last);
        return {last, d};
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_byte(logic [7:0] d, logic s, logic e);
        @(negedge clk);
        wr_valid = 1; wr_data = d; wr_sof = s; wr_eof = e;
        #1;
        while (!wr_ready) begin
            @(negedge clk);
            #1;
        end
        expq.push_back(pack_exp(d, e));
    endtask

    task automatic write_idle();
        @(negedge clk);
        wr_valid = 0; wr_sof = 0; wr_eof = 0;
    endtask

    task automatic write_frame(int len, int gap_pct);
        for (int i = 0; i < len; i++) begin
            write_byte(8'($urandom), i == 0, i == len - 1);
            while (($urandom % 100) < gap_pct) write_idle();
        end
        write_idle();
    endtask

    task automatic read_frames(int n, int rdy_pct);
        for (int f = 0; f < n; f++) begin
            bit got_last = 0;
            logic [8:0] e;
            while (!got_last) begin
                bit r;
                @(negedge clk);
                r = (($urandom % 100) < rdy_pct);
                tx_ready = r;
                #1;
                if (tx_valid) chk(rd_status == 2'b01, "R2", "code while sending", rd_status, 1);
                if (tx_valid && r) begin
                    if (expq.size() == 0) begin
                        chk(0, "R4", "unexpected byte", tx_data, -1);
                        got_last = 1;
                    end else begin
                        e = expq.pop_front();
                        chk(tx_data == e[7:0], "R4", "byte order", tx_data, e[7:0]);
                        chk(tx_last == e[8], "R4", "last mark", tx_last, e[8]);
                        got_last = tx_last;
                    end
                end
            end
            @(negedge clk);
            tx_ready = 0;
            #1;
            chk(rd_status == 2'b10, "R5", "code after last", rd_status, 2);
            chk(!tx_valid && st_ready, "R5", "wait handshake", {tx_valid, st_ready}, 1);
            repeat ($urandom % 3) begin
                @(negedge clk);
                #1;
                chk(rd_status == 2'b10 && !tx_valid, "R5", "holding in wait", rd_status, 2);
            end
            @(negedge clk);
            st_valid = 1; st_word = status_for(rframe);
            @(negedge clk);
            st_valid = 0;
            #1;
            chk(ret_valid, "R6", "write-back strobe", ret_valid, 1);
            chk(ret_word == status_for(rframe), "R6", "write-back word", ret_word, status_for(rframe));
            chk(rd_status == 2'b11, "R2", "code in write-back", rd_status, 3);
            @(negedge clk);
            #1;
            chk(!ret_valid, "R6", "strobe one cycle", ret_valid, 0);
            chk(rd_status == 2'b00, "R6", "back to idle", rd_status, 0);
            rframe++;
        end
    endtask

    task automatic check_all_zero(string req);
        @(negedge clk);
        #1;
        chk(rd_status == 0 && !fifo_full && !fifo_nempty && !wr_active, req, "all-zero status",
            {rd_status, fifo_full, fifo_nempty, wr_active}, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_all_zero("R1");
        chk(!tx_valid && !ret_valid, "R1", "outputs idle after reset", {tx_valid, ret_valid}, 0);

        // partial frame: no end mark yet
        write_byte(8'h11, 1, 0);
        write_byte(8'h22, 0, 0);
        write_byte(8'h33, 0, 0);
        write_idle();
        repeat (4) @(negedge clk);
        #1;
        chk(rd_status == 2'b00 && !tx_valid, "R3", "idle with partial frame", rd_status, 0);
        chk(fifo_nempty, "R8", "not-empty with partial frame", fifo_nempty, 1);
        chk(wr_active, "R9", "write-active inside frame", wr_active, 1);
        write_byte(8'h44, 0, 1);
        write_idle();
        #1;
        chk(!wr_active, "R9", "write-active after end mark", wr_active, 0);
        read_frames(1, 100);
        check_all_zero("R1");

        // full queue with a 64-byte frame, transmitter held off
        tx_ready = 0;
        write_frame(64, 0);
        #1;
        chk(fifo_full, "R7", "full at 64 bytes", fifo_full, 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            wr_valid = 1; wr_data = 8'hEE; wr_sof = 1; wr_eof = 1;
            #1;
            chk(!wr_ready, "R7", "no accept when full", wr_ready, 0);
        end
        write_idle();
        read_frames(1, 70);
        check_all_zero("R7");

        // two queued frames, flush while ready to send
        write_frame(5, 0);
        write_frame(7, 0);
        @(negedge clk);
        #1;
        chk(rd_status == 2'b01, "R2", "send with frames queued", rd_status, 1);
        flush = 1;
        @(negedge clk);
        flush = 0;
        #1;
        chk(rd_status == 2'b11, "R10", "code during flush", rd_status, 3);
        @(negedge clk);
        #1;
        chk(rd_status == 2'b00 && !fifo_nempty, "R10", "empty after flush", {rd_status, fifo_nempty}, 0);
        expq.delete();
        tx_ready = 1;
        repeat (5) begin
            @(negedge clk);
            #1;
            chk(!tx_valid, "R10", "no stale bytes", tx_valid, 0);
        end
        tx_ready = 0;

        // random frames with concurrent writer and reader, writer stalls on space
        fork
            for (int f = 0; f < 10; f++) write_frame(1 + int'($urandom % 60), 30);
            read_frames(10, 60);
        join
        check_all_zero("R1");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule